// File: doc/BRIEF.md
# Conversion Sequencer with Active-Low Data-Ready

This block decides when a delta-sigma converter runs its conversions and tells the host when a new result can be read. It divides the system clock down to a modulator tick, counts those ticks for each conversion, and at the end of the count captures the 24-bit word presented by the decimation filter into an output buffer. It handles start/sync, power-down and soft-reset request pulses. A mode bit chooses between one conversion per start (single-shot) and back-to-back conversions (continuous). A turbo bit halves the modulator period. A 3-bit rate code picks the conversion length from a parameter table.

The host sees an active-low data-ready line. It falls when a fresh result lands in the buffer and rises again as soon as the host issues a read-data request. When a new result arrives while the previous one is still unread, the line is driven high for two modulator periods before it falls again, so an edge-sensitive host never misses a result. The filter arithmetic and the analog front end are outside this block. The filter word is simply sampled on the clock edge that ends the conversion count.

Top module: `cs_conv_seq`

## Requirements
- R1: After reset, `drdy_n` is 1 and `rd_data` is 0.
- R2: In single-shot mode (`cont_mode`=0), a `start_req` pulse sampled on clock edge E0 makes `drdy_n` fall, and `rd_data` take the value of `flt_word`, on edge E0 + T·P. T is `CONV_TICKS[rate_sel]` and P is the modulator period in clocks: `CLK_PER_MOD` with `turbo`=0.
- R3: After a single-shot result, no further result is produced without a new start: `drdy_n` and `rd_data` stay unchanged until a read, and `drdy_n` stays 1 after the read.
- R4: In continuous mode (`cont_mode`=1), each later result lands T·P clocks after the previous one without any new request.
- R5: With `turbo`=1 the modulator period is `CLK_PER_MOD`/2 clocks, so a conversion takes half as many clocks for the same rate code.
- R6: The rate code `rate_sel` (0 to 7) selects the conversion length `CONV_TICKS[rate_sel]` in modulator ticks. The code is captured when a conversion begins.
- R7: A `read_req` pulse while `drdy_n` is 0 makes `drdy_n` 1 on the next clock edge.
- R8: If a result completes while `drdy_n` is 0, `drdy_n` goes high and the buffer takes the new word on that edge. `drdy_n` then stays high for exactly 2 modulator periods before falling. No high pulse of `drdy_n` that ends in a fall is shorter than 2 modulator periods.
- R9: A `start_req` during a running conversion restarts its count from zero, so the result lands T·P clocks after the last start.
- R10: A `pdown_req` pulse stops conversions, and no result is produced while powered down. A later `start_req` wakes the block and runs a full conversion.
- R11: A `sreset_req` pulse clears `rd_data` to 0, drives `drdy_n` to 1 on the next edge and returns the block to idle, with no further results.
- R12: `rd_data` changes only on the edge where a conversion completes, or on a soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Start/sync request pulse |
| pdown_req | input | 1 | Power-down request pulse |
| sreset_req | input | 1 | Soft reset request pulse |
| read_req | input | 1 | Read-data command latched pulse |
| cont_mode | input | 1 | 1 = continuous, 0 = single-shot |
| turbo | input | 1 | 1 = modulator period halved |
| rate_sel | input | 3 | Data-rate code, index into the length table |
| flt_word | input | DW | Result word from the decimation filter |
| rd_data | output | DW | Buffered most recent result |
| drdy_n | output | 1 | Data-ready, active low |

## Verification
A table of single-shot runs covers normal and turbo modulator periods across short, long and out-of-range-ended rate codes, with a different data word each time. Each run measures the exact clock count from start to the falling data-ready edge, so a wrong length entry, a wrong divider or a missing turbo halving shows up as a count mismatch rather than only a late result. Directed sequences then separate the ordering cases: back-to-back results with no read (the two-period high pulse and the buffer update on the same edge), a restart in mid-conversion, power-down followed by wake, idling after a single shot, and a soft reset with a result pending.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_PDN  = 2'd2
  } seq_state_e;

  localparam int unsigned RATE_CODES = 8;
  localparam int unsigned HIGH_TICKS = 2;
endpackage

// File: rtl/cs_modtick.sv
module cs_modtick #(
  parameter int unsigned CLK_PER_MOD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic turbo,
  output logic tick
);
  localparam int unsigned CW   = $clog2(CLK_PER_MOD + 1);
  localparam int unsigned HALF = CLK_PER_MOD / 2;

  logic [CW-1:0] pcnt_q, pcnt_d, lim_m1;

  always_comb begin
    lim_m1 = turbo ? CW'(HALF - 1) : CW'(CLK_PER_MOD - 1);
    tick   = (pcnt_q >= lim_m1);
    if (restart || tick) pcnt_d = '0;
    else                 pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
  import cs_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CONV_TICKS [RATE_CODES] = '{12800, 5688, 2844, 1462, 775, 426, 256, 256}
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pdown,
  input  logic       sreset,
  input  logic       cont,
  input  logic       tick,
  input  logic [2:0] rate,
  output seq_state_e state,
  output logic       conv_done,
  output logic       tick_restart
);
  seq_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q, len_d, cnt_inc, len_sel;

  always_comb begin
    len_sel      = LEN_W'(CONV_TICKS[rate]);
    cnt_inc      = cnt_q + 1'b1;
    st_d         = st_q;
    cnt_d        = cnt_q;
    len_d        = len_q;
    conv_done    = 1'b0;
    tick_restart = 1'b0;
    if (sreset) begin
      st_d         = ST_IDLE;
      cnt_d        = '0;
      tick_restart = 1'b1;
    end else if (pdown) begin
      st_d  = ST_PDN;
      cnt_d = '0;
    end else if (start) begin
      st_d         = ST_CONV;
      cnt_d        = '0;
      len_d        = len_sel;
      tick_restart = 1'b1;
    end else if (st_q == ST_CONV && tick) begin
      if (cnt_inc == len_q) begin
        conv_done = 1'b1;
        cnt_d     = '0;
        if (cont) len_d = len_sel;
        else      st_d  = ST_IDLE;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      len_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/cs_drdy.sv
module cs_drdy
  import cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic done,
  input  logic rd_req,
  input  logic sreset,
  output logic drdy_n
);
  logic       drdy_q, drdy_d, pend_q, pend_d;
  logic [1:0] hi_q, hi_d, hi_inc;

  always_comb begin
    hi_inc = (tick && hi_q != 2'(HIGH_TICKS)) ? hi_q + 1'b1 : hi_q;
    drdy_d = drdy_q;
    hi_d   = hi_inc;
    pend_d = pend_q;
    if (done) begin
      if (drdy_q) begin
        if (hi_inc == 2'(HIGH_TICKS)) begin
          drdy_d = 1'b0;
          pend_d = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end else begin
        drdy_d = 1'b1;
        hi_d   = '0;
        pend_d = 1'b1;
      end
    end else if (rd_req || sreset) begin
      if (!drdy_q) begin
        drdy_d = 1'b1;
        hi_d   = '0;
      end
      if (sreset || !drdy_q) pend_d = 1'b0;
    end else if (pend_q && drdy_q && hi_inc == 2'(HIGH_TICKS)) begin
      drdy_d = 1'b0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q <= 1'b1;
      hi_q   <= 2'(HIGH_TICKS);
      pend_q <= 1'b0;
    end else begin
      drdy_q <= drdy_d;
      hi_q   <= hi_d;
      pend_q <= pend_d;
    end
  end

  assign drdy_n = drdy_q;
endmodule

// File: rtl/cs_conv_seq.sv
module cs_conv_seq
  import cs_pkg::*;
#(
  parameter int unsigned DW          = 24,
  parameter int unsigned CLK_PER_MOD = 4,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned CONV_TICKS [RATE_CODES] = '{12800, 5688, 2844, 1462, 775, 426, 256, 256}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          pdown_req,
  input  logic          sreset_req,
  input  logic          read_req,
  input  logic          cont_mode,
  input  logic          turbo,
  input  logic [2:0]    rate_sel,
  input  logic [DW-1:0] flt_word,
  output logic [DW-1:0] rd_data,
  output logic          drdy_n
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          mod_tick, tick_restart, conv_done;
  seq_state_e    st;
  logic [DW-1:0] buf_q, buf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cs_modtick #(.CLK_PER_MOD(CLK_PER_MOD)) u_tick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (tick_restart),
    .turbo   (turbo),
    .tick    (mod_tick)
  );

  cs_sequencer #(.LEN_W(LEN_W), .CONV_TICKS(CONV_TICKS)) u_seq (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start        (start_req),
    .pdown        (pdown_req),
    .sreset       (sreset_req),
    .cont         (cont_mode),
    .tick         (mod_tick),
    .rate         (rate_sel),
    .state        (st),
    .conv_done    (conv_done),
    .tick_restart (tick_restart)
  );

  cs_drdy u_drdy (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (mod_tick),
    .done   (conv_done),
    .rd_req (read_req),
    .sreset (sreset_req),
    .drdy_n (drdy_n)
  );

  always_comb begin
    buf_d = buf_q;
    if (sreset_req)     buf_d = '0;
    else if (conv_done) buf_d = flt_word;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) buf_q <= '0;
    else            buf_q <= buf_d;
  end

  assign rd_data = buf_q;
endmodule

// File: rtl/cs_conv_seq_chk.sv
module cs_conv_seq_chk #(
  parameter int unsigned DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          conv_done,
  input logic          read_req,
  input logic          sreset_req,
  input logic          drdy_n,
  input logic [DW-1:0] rd_data
);
  logic [1:0] hi_ticks_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  hi_ticks_q <= 2'd2;
    else if (!drdy_n)            hi_ticks_q <= 2'd0;
    else if (tick && hi_ticks_q != 2'd3) hi_ticks_q <= hi_ticks_q + 1'b1;
  end

  a_r7_read_release: assert property (@(posedge clk) disable iff (!rst_n)
    (read_req && !drdy_n) |=> drdy_n);

  a_r8_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> (hi_ticks_q >= 2'd2));

  a_r12_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !sreset_req) |=> $stable(rd_data));

  a_r11_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_req |=> (rd_data == '0 && drdy_n));
endmodule

bind cs_conv_seq cs_conv_seq_chk #(.DW(DW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (mod_tick),
  .conv_done  (conv_done),
  .read_req   (read_req),
  .sreset_req (sreset_req),
  .drdy_n     (drdy_n),
  .rd_data    (rd_data)
);

// File: tb/test_cs_conv_seq.sv
`timescale 1ns/1ps
module test_cs_conv_seq;
  localparam int unsigned DW = 24;
  localparam int unsigned PER = 4;
  localparam int unsigned TB_TICKS [8] = '{6, 8, 10, 12, 14, 16, 18, 18};
  // vector: [27] turbo, [26:24] rate code, [23:0] filter word
  localparam int NVEC = 5;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 24'h123456},
    {1'b0, 3'd3, 24'hABCDEF},
    {1'b1, 3'd0, 24'h800001},
    {1'b1, 3'd6, 24'h7FFFFF},
    {1'b0, 3'd7, 24'h00A5A5}
  };

  logic clk = 1'b0;
  logic rst_n, start_req, pdown_req, sreset_req, read_req, cont_mode, turbo;
  logic [2:0] rate_sel;
  logic [DW-1:0] flt_word, rd_data;
  logic drdy_n;
  int checks = 0;
  int fails = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  cs_conv_seq #(.DW(DW), .CLK_PER_MOD(PER), .LEN_W(16), .CONV_TICKS(TB_TICKS)) i_cs_conv_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .pdown_req(pdown_req),
    .sreset_req(sreset_req), .read_req(read_req), .cont_mode(cont_mode),
    .turbo(turbo), .rate_sel(rate_sel), .flt_word(flt_word),
    .rd_data(rd_data), .drdy_n(drdy_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_req = 1'b1; step(1); start_req = 1'b0;
  endtask

  task automatic do_read(input string req);
    read_req = 1'b1; step(1); read_req = 1'b0;
    check(drdy_n == 1'b1, req, drdy_n, 1);
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    while (drdy_n && n < 4000) begin step(1); n++; end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    int exp_n;
    rst_n = 1'b0; start_req = 0; pdown_req = 0; sreset_req = 0; read_req = 0;
    cont_mode = 0; turbo = 0; rate_sel = 0; flt_word = '0;
    step(4); rst_n = 1'b1; step(4);
    // R1 reset state
    check(drdy_n == 1'b1, "R1 drdy_n", drdy_n, 1);
    check(rd_data == '0, "R1 rd_data", rd_data, 0);

    // R2 R5 R6 single-shot table
    for (int i = 0; i < NVEC; i++) begin
      turbo = VEC[i][27]; rate_sel = VEC[i][26:24]; flt_word = VEC[i][23:0];
      exp_n = TB_TICKS[VEC[i][26:24]] * (VEC[i][27] ? PER / 2 : PER);
      pulse_start();
      wait_fall(n);
      check(n == exp_n, "R2/R5/R6 conversion clocks", n, exp_n);
      check(rd_data == VEC[i][23:0], "R2 result word", rd_data, VEC[i][23:0]);
      do_read("R7 read release");
    end
    turbo = 0; rate_sel = 0;

    // R4 R8 continuous, no reads
    cont_mode = 1; flt_word = 24'h111111;
    pulse_start();
    step(24);
    check(drdy_n == 1'b0, "R4 first result", drdy_n, 0);
    check(rd_data == 24'h111111, "R4 first word", rd_data, 24'h111111);
    flt_word = 24'h222222;
    step(24);
    check(drdy_n == 1'b1, "R8 high on unread result", drdy_n, 1);
    check(rd_data == 24'h222222, "R4 R8 second word", rd_data, 24'h222222);
    step(7);
    check(drdy_n == 1'b1, "R8 still high", drdy_n, 1);
    step(1);
    check(drdy_n == 1'b0, "R8 falls after 2 periods", drdy_n, 0);

    // R10 power-down stops conversions
    pdown_req = 1'b1; step(1); pdown_req = 1'b0;
    flt_word = 24'h333333;
    step(100);
    check(drdy_n == 1'b0, "R10 no result in power-down", drdy_n, 0);
    check(rd_data == 24'h222222, "R10 buffer kept", rd_data, 24'h222222);
    do_read("R7 read release");
    cont_mode = 0;
    pulse_start();
    wait_fall(n);
    check(n == 24, "R10 wake conversion", n, 24);
    check(rd_data == 24'h333333, "R10 wake word", rd_data, 24'h333333);
    do_read("R7 read release");

    // R9 restart during conversion
    flt_word = 24'h444444;
    pulse_start();
    step(11);
    pulse_start();
    wait_fall(n);
    check(n == 24, "R9 restart count", n, 24);

    // R3 R12 single-shot idles
    step(100);
    check(drdy_n == 1'b0, "R3 drdy held", drdy_n, 0);
    check(rd_data == 24'h444444, "R3 R12 buffer held", rd_data, 24'h444444);
    do_read("R7 read release");
    step(100);
    check(drdy_n == 1'b1, "R3 no new result", drdy_n, 1);

    // R11 soft reset
    flt_word = 24'h555555;
    pulse_start();
    wait_fall(n);
    check(rd_data == 24'h555555, "R11 pre word", rd_data, 24'h555555);
    sreset_req = 1'b1; step(1); sreset_req = 1'b0;
    check(drdy_n == 1'b1, "R11 drdy high", drdy_n, 1);
    check(rd_data == '0, "R11 buffer cleared", rd_data, 0);
    cont_mode = 1;
    step(100);
    check(drdy_n == 1'b1, "R11 idle after reset", drdy_n, 1);
    check(rd_data == '0, "R11 buffer stays clear", rd_data, 0);

    report();
  end
endmodule